// File: doc/BRIEF.md
# Precise Overflow Sample Recorder

This block sits beside a single event counter. Each time that counter overflows, it writes one fixed-format record into a memory buffer without software involvement. A record holds the instruction pointer of the instruction that retires in the overflow cycle, or of the first instruction that retires after it, followed by three captured state words. The block also returns a reload strobe that carries the programmed sample period, so the counter restarts after every overflow.

Software supplies the buffer base address, the buffer size in bytes and an interrupt threshold. The block keeps a byte write index into the buffer. The interrupt line is driven only by the buffer fill level, never by a single sample. It stays high until software pulses the index clear, which also clears the sticky lost-sample flag. An overflow that arrives while a record is still pending, or while the buffer has no room, is dropped and sets that flag.

Top module: `ovf_sample_rec`

## Requirements
- R1: After reset, mem_vld_o, reload_o, lost_o and irq_o are low (with a nonzero threshold) and wr_idx_o is 0.
- R2: A record is four 64-bit beats in a fixed order: the instruction pointer, then state words 0, 1 and 2 taken from state_i bits [63:0], [127:64] and [191:128]. Beat k goes to address base_i + wr_idx + 8*k, where wr_idx is the index at capture. Every accepted overflow produces exactly one record, and no other writes occur.
- R3: The instruction pointer and the state words are taken in the overflow cycle if ret_vld_i is high in that cycle. Otherwise they are taken in the first later cycle in which ret_vld_i is high.
- R4: A beat transfers on a cycle where mem_vld_o and mem_rdy_i are both high. While mem_vld_o is high and mem_rdy_i is low, mem_vld_o, mem_addr_o and mem_data_o stay unchanged.
- R5: wr_idx_o rises by 32 in the cycle after the final beat of a record is accepted, and it changes at no other time except on clear.
- R6: One cycle after every overflow pulse, including dropped ones, reload_o is high for one cycle and reload_val_o equals period_i.
- R7: An overflow that arrives while a record is waiting for its instruction pointer or is being written is dropped. lost_o goes high in the next cycle.
- R8: An overflow that arrives while wr_idx + 32 > limit_i is dropped. lost_o goes high in the next cycle.
- R9: irq_o is high exactly when wr_idx_o >= irq_th_i. It therefore stays high until a clear.
- R10: An idx_clr_i pulse sets wr_idx_o to 0 and lost_o to 0 in the next cycle. The lost flag is otherwise sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ovf_i | input | 1 | Counter overflow pulse |
| ret_vld_i | input | 1 | An instruction retires this cycle |
| ret_ip_i | input | 64 | Pointer of the retiring instruction |
| state_i | input | 192 | Three state words to capture |
| base_i | input | ADDR_W | Buffer base byte address |
| limit_i | input | IDX_W | Buffer size in bytes |
| irq_th_i | input | IDX_W | Interrupt threshold on the write index |
| period_i | input | CNT_W | Sample period reloaded into the counter |
| idx_clr_i | input | 1 | Software clear of the write index and the lost flag |
| mem_vld_o | output | 1 | Write beat valid |
| mem_rdy_i | input | 1 | Write beat accepted |
| mem_addr_o | output | ADDR_W | Write beat byte address |
| mem_data_o | output | 64 | Write beat data |
| reload_o | output | 1 | Counter reload strobe |
| reload_val_o | output | CNT_W | Value to load into the counter |
| irq_o | output | 1 | Buffer threshold interrupt |
| wr_idx_o | output | IDX_W | Current write index in bytes |
| lost_o | output | 1 | Sticky lost-sample flag |

## Verification
The earliest first beat appears one cycle after the capture cycle, which is either the overflow cycle or the later retire cycle. Each following beat depends on the handshake. The index step, the reload strobe and the lost flag all land one cycle after the cycle that causes them, and irq_o follows the index with no added delay. The bench drives inputs on the falling edge and samples 1 ns later. Its model moves the index, busy state and lost state forward only after the checks for that cycle, so each expected value lines up with the register stage that produces it. Beats are compared against a queue of predicted records, and the queue must be empty once the run has drained.

// File: rtl/osr_pkg.sv
package osr_pkg;
  localparam int unsigned OSR_DATA_W     = 64;
  localparam int unsigned OSR_NUM_STATE  = 3;
  localparam int unsigned OSR_REC_WORDS  = 1 + OSR_NUM_STATE;
  localparam int unsigned OSR_WORD_BYTES = OSR_DATA_W / 8;
  localparam int unsigned OSR_REC_BYTES  = OSR_REC_WORDS * OSR_WORD_BYTES;
  localparam int unsigned OSR_BEAT_W     = $clog2(OSR_REC_WORDS);
  localparam int unsigned OSR_BYTE_SH    = $clog2(OSR_WORD_BYTES);
endpackage

// File: rtl/osr_capture.sv
module osr_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_acc_i,
  input  logic ret_vld_i,
  output logic fire_o,
  output logic wait_o
);
  logic wait_q;

  // overflow taken but no retirement yet: hold until the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wait_q <= 1'b0;
    else if (ret_vld_i) wait_q <= 1'b0;
    else if (ovf_acc_i) wait_q <= 1'b1;
  end

  assign fire_o = (ovf_acc_i | wait_q) & ret_vld_i;
  assign wait_o = wait_q;
endmodule

// File: rtl/osr_writer.sv
module osr_writer
  import osr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                fire_i,
  input  logic [ADDR_W-1:0]                   rec_addr_i,
  input  logic [OSR_DATA_W-1:0]               ip_i,
  input  logic [OSR_NUM_STATE*OSR_DATA_W-1:0] state_i,
  input  logic                                rdy_i,
  output logic                                vld_o,
  output logic [ADDR_W-1:0]                   addr_o,
  output logic [OSR_DATA_W-1:0]               data_o,
  output logic                                done_o,
  output logic                                busy_o
);
  localparam logic [OSR_BEAT_W-1:0] LAST_BEAT = OSR_BEAT_W'(OSR_REC_WORDS - 1);

  logic                  act_q;
  logic [OSR_BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0]     rec_addr_q;
  logic [OSR_DATA_W-1:0] words_q [OSR_REC_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      beat_q     <= '0;
      rec_addr_q <= '0;
      for (int k = 0; k < OSR_REC_WORDS; k++) words_q[k] <= '0;
    end else if (fire_i) begin
      act_q      <= 1'b1;
      beat_q     <= '0;
      rec_addr_q <= rec_addr_i;
      words_q[0] <= ip_i;
      for (int k = 0; k < OSR_NUM_STATE; k++)
        words_q[k+1] <= state_i[k*OSR_DATA_W +: OSR_DATA_W];
    end else if (act_q && rdy_i) begin
      if (beat_q == LAST_BEAT) act_q  <= 1'b0;
      else                     beat_q <= beat_q + 1'b1;
    end
  end

  assign vld_o  = act_q;
  assign addr_o = rec_addr_q + (ADDR_W'(beat_q) << OSR_BYTE_SH);
  assign data_o = words_q[beat_q];
  assign done_o = act_q & rdy_i & (beat_q == LAST_BEAT);
  assign busy_o = act_q;
endmodule

// File: rtl/osr_bufctl.sv
module osr_bufctl
  import osr_pkg::*;
#(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovf_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] limit_i,
  input  logic [IDX_W-1:0] irq_th_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             acc_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             lost_o,
  output logic             irq_o,
  output logic             reload_o,
  output logic [CNT_W-1:0] reload_val_o
);
  logic [IDX_W-1:0] idx_q;
  logic             lost_q, reload_q;
  logic [CNT_W-1:0] reload_val_q;
  logic [IDX_W:0]   idx_next;
  logic             full;

  assign idx_next = {1'b0, idx_q} + (IDX_W+1)'(OSR_REC_BYTES);
  assign full     = idx_next > {1'b0, limit_i};
  assign acc_o    = ovf_i & ~busy_i & ~full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      lost_q <= 1'b0;
    end else if (clr_i) begin
      idx_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (done_i)                      idx_q  <= idx_next[IDX_W-1:0];
      if (ovf_i && (busy_i || full))   lost_q <= 1'b1;
    end
  end

  // reload follows every overflow, taken or dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q     <= 1'b0;
      reload_val_q <= '0;
    end else begin
      reload_q     <= ovf_i;
      reload_val_q <= period_i;
    end
  end

  assign wr_idx_o     = idx_q;
  assign lost_o       = lost_q;
  assign irq_o        = idx_q >= irq_th_i;
  assign reload_o     = reload_q;
  assign reload_val_o = reload_val_q;
endmodule

// File: rtl/ovf_sample_rec.sv
module ovf_sample_rec
  import osr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned CNT_W  = 48
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                ovf_i,
  input  logic                                ret_vld_i,
  input  logic [OSR_DATA_W-1:0]               ret_ip_i,
  input  logic [OSR_NUM_STATE*OSR_DATA_W-1:0] state_i,
  input  logic [ADDR_W-1:0]                   base_i,
  input  logic [IDX_W-1:0]                    limit_i,
  input  logic [IDX_W-1:0]                    irq_th_i,
  input  logic [CNT_W-1:0]                    period_i,
  input  logic                                idx_clr_i,
  output logic                                mem_vld_o,
  input  logic                                mem_rdy_i,
  output logic [ADDR_W-1:0]                   mem_addr_o,
  output logic [OSR_DATA_W-1:0]               mem_data_o,
  output logic                                reload_o,
  output logic [CNT_W-1:0]                    reload_val_o,
  output logic                                irq_o,
  output logic [IDX_W-1:0]                    wr_idx_o,
  output logic                                lost_o
);
  logic ovf_acc, cap_fire, cap_wait, wr_busy, wr_done, busy;
  logic [ADDR_W-1:0] rec_addr;

  assign busy     = cap_wait | wr_busy;
  assign rec_addr = base_i + ADDR_W'(wr_idx_o);

  osr_bufctl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_buf (
    .clk_i, .rst_ni,
    .ovf_i        (ovf_i),
    .busy_i       (busy),
    .done_i       (wr_done),
    .clr_i        (idx_clr_i),
    .limit_i      (limit_i),
    .irq_th_i     (irq_th_i),
    .period_i     (period_i),
    .acc_o        (ovf_acc),
    .wr_idx_o     (wr_idx_o),
    .lost_o       (lost_o),
    .irq_o        (irq_o),
    .reload_o     (reload_o),
    .reload_val_o (reload_val_o)
  );

  osr_capture u_cap (
    .clk_i, .rst_ni,
    .ovf_acc_i (ovf_acc),
    .ret_vld_i (ret_vld_i),
    .fire_o    (cap_fire),
    .wait_o    (cap_wait)
  );

  osr_writer #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni,
    .fire_i     (cap_fire),
    .rec_addr_i (rec_addr),
    .ip_i       (ret_ip_i),
    .state_i    (state_i),
    .rdy_i      (mem_rdy_i),
    .vld_o      (mem_vld_o),
    .addr_o     (mem_addr_o),
    .data_o     (mem_data_o),
    .done_o     (wr_done),
    .busy_o     (wr_busy)
  );
endmodule

// File: rtl/osr_checker.sv
module osr_checker
  import osr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned CNT_W  = 48
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ovf_i,
  input logic                  idx_clr_i,
  input logic [IDX_W-1:0]      irq_th_i,
  input logic [CNT_W-1:0]      period_i,
  input logic                  mem_vld_o,
  input logic                  mem_rdy_i,
  input logic [ADDR_W-1:0]     mem_addr_o,
  input logic [OSR_DATA_W-1:0] mem_data_o,
  input logic                  reload_o,
  input logic [CNT_W-1:0]      reload_val_o,
  input logic                  irq_o,
  input logic [IDX_W-1:0]      wr_idx_o,
  input logic                  lost_o
);
  localparam logic [IDX_W-1:0] STEP = IDX_W'(OSR_REC_BYTES);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_vld_o && !mem_rdy_i) |=> (mem_vld_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_clr_i |=> (wr_idx_o == $past(wr_idx_o) || wr_idx_o == $past(wr_idx_o) + STEP));

  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> (reload_o && reload_val_o == $past(period_i)));

  assert_lost_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !idx_clr_i) |=> lost_o);

  assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !idx_clr_i) |=> (irq_o || irq_th_i != $past(irq_th_i)));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_clr_i |=> (wr_idx_o == '0 && !lost_o));
endmodule

bind ovf_sample_rec osr_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ovf_i        (ovf_i),
  .idx_clr_i    (idx_clr_i),
  .irq_th_i     (irq_th_i),
  .period_i     (period_i),
  .mem_vld_o    (mem_vld_o),
  .mem_rdy_i    (mem_rdy_i),
  .mem_addr_o   (mem_addr_o),
  .mem_data_o   (mem_data_o),
  .reload_o     (reload_o),
  .reload_val_o (reload_val_o),
  .irq_o        (irq_o),
  .wr_idx_o     (wr_idx_o),
  .lost_o       (lost_o)
);

// File: tb/ovf_sample_rec_tb_top.sv
`timescale 1ns/1ps
module ovf_sample_rec_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned CNT_W  = 48;
  localparam logic [ADDR_W-1:0] BASE = 32'h8000_1000;
  localparam int unsigned LIM = 128;
  localparam int unsigned TH  = 96;
  localparam logic [CNT_W-1:0] PER = 48'h0000_0123_4567;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ovf_i = 1'b0, ret_vld_i = 1'b0, idx_clr_i = 1'b0, mem_rdy_i = 1'b0;
  logic [63:0]       ret_ip_i = '0;
  logic [191:0]      state_i = '0;
  logic              mem_vld_o, reload_o, irq_o, lost_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [63:0]       mem_data_o;
  logic [CNT_W-1:0]  reload_val_o;
  logic [IDX_W-1:0]  wr_idx_o;

  always #10 clk_i = ~clk_i;

  ovf_sample_rec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
    .clk_i, .rst_ni, .ovf_i, .ret_vld_i, .ret_ip_i, .state_i,
    .base_i(BASE), .limit_i(IDX_W'(LIM)), .irq_th_i(IDX_W'(TH)), .period_i(PER),
    .idx_clr_i, .mem_vld_o, .mem_rdy_i, .mem_addr_o, .mem_data_o,
    .reload_o, .reload_val_o, .irq_o, .wr_idx_o, .lost_o
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int unsigned idx_m = 0;
  bit lost_m = 0, busy_m = 0, pend_m = 0, prev_ovf = 0;
  int bm = 0;
  logic [ADDR_W-1:0] ea[$];
  logic [63:0]       ed[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit ovf, bit rv, bit rdy, bit clr);
    bit fin;
    @(negedge clk_i);
    ovf_i = ovf; ret_vld_i = rv; mem_rdy_i = rdy; idx_clr_i = clr;
    ret_ip_i = {$urandom, $urandom};
    state_i  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    #1;
    fin = 0;
    chk("R6 reload", 64'(reload_o), 64'(prev_ovf));
    if (prev_ovf) chk("R6 value", 64'(reload_val_o), 64'(PER));
    chk("R5 index", 64'(wr_idx_o), 64'(idx_m));
    chk("R7 R8 lost", 64'(lost_o), 64'(lost_m));
    chk("R9 irq", 64'(irq_o), 64'(idx_m >= TH));
    if (mem_vld_o && mem_rdy_i) begin
      if (ea.size() == 0) chk("R2 unexpected beat", 64'(1), 64'(0));
      else begin
        chk("R2 addr", 64'(mem_addr_o), 64'(ea.pop_front()));
        chk(bm == 0 ? "R3 ip" : "R2 data", mem_data_o, ed.pop_front());
        fin = (bm == 3);
        bm = (bm + 1) % 4;
      end
    end
    prev_ovf = ovf;
    if (clr) begin
      idx_m = 0; lost_m = 0;  // R10
    end else begin
      if (ovf) begin
        if (busy_m || idx_m + 32 > LIM) lost_m = 1;  // R7, R8
        else begin busy_m = 1; pend_m = 1; end
      end
      if (pend_m && rv) begin
        pend_m = 0;
        for (int k = 0; k < 4; k++) ea.push_back(BASE + ADDR_W'(idx_m + 8*k));
        ed.push_back(ret_ip_i);
        for (int k = 0; k < 3; k++) ed.push_back(state_i[k*64 +: 64]);
      end
      if (fin) begin idx_m += 32; busy_m = 0; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 vld", 64'(mem_vld_o), 0);
    chk("R1 idx", 64'(wr_idx_o), 0);
    chk("R1 lost", 64'(lost_o), 0);
    chk("R1 reload", 64'(reload_o), 0);
    chk("R1 irq", 64'(irq_o), 0);
    rst_ni = 1'b1;
    // R3: retire in the overflow cycle
    step(1, 1, 1, 0);
    repeat (5) step(0, 0, 1, 0);
    // R3/R7: late retire, overflows in between dropped
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    step(1, 0, 0, 0);
    repeat (8) step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    // R8/R9: fill buffer, then overflow while full
    for (int r = 0; r < 5; r++) begin
      step(1, 1, 1, 0);
      repeat (6) step(0, 0, $urandom_range(0, 3) != 0, 0);
    end
    step(0, 0, 1, 1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit o, c;
      o = ($urandom_range(0, 99) < 15);
      c = !o && !busy_m && idx_m >= LIM - 32 && ($urandom_range(0, 7) == 0);
      step(o, $urandom_range(0, 1), $urandom_range(0, 9) < 7, c);
    end
    repeat (30) step(0, 1, 1, 0);
    chk("R2 drained", 64'(ea.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule